// File: doc/BRIEF.md
# Forwarded-Clock Pixel Word Deserializer

This block is the receive end of a short, source-synchronous video link. One or more serial lanes are sampled on the bit clock that travels with them. No clock or data recovery is attempted. Each 30-bit word carries one pixel: three 8-bit colour channels, horizontal sync, vertical sync, data enable, two spare general-purpose bits and an even-parity bit. A frame strobe that travels alongside the lanes marks the first bit slot of a word. From that point a slot counter runs freely and cuts the stream into words.

The word is spread round-robin over `LANES` lanes, so each lane runs at 1/`LANES` of the single-lane rate. A word takes `SLOTS = 30 / LANES` clock cycles. When the last slot of a word is sampled, the block registers the unpacked fields, recomputes parity and raises a one-cycle pixel-valid pulse. A parity error flag may accompany that pulse. `LANES` must divide 30 and be at most 10, and it must match the transmitter.

Top module: `pixel_deser`

## Requirements
- R1: A word's bit 29 is transmitted first. The fields are: red = bits 29..22, green = bits 21..14, blue = bits 13..6, hsync = bit 5, vsync = bit 4, den = bit 3, gp = bits 2..1, parity = bit 0. Each field is presented MSB-aligned on its own output port.
- R2: In slot k of a word (k = 0 .. SLOTS-1), lane l carries word bit 29 - (k*LANES + l). Lane 0 holds the earliest bit of each slot.
- R3: Until the strobe has been seen high once after reset, no pixel-valid pulse is produced, whatever the lane data.
- R4: A strobe high marks slot 0. After that the slot counter runs freely, and a word completes every SLOTS cycles without further strobes.
- R5: pix_valid is high for exactly one cycle, the cycle after the clock edge that samples the word's last slot.
- R6: par_err equals the XOR of all 30 received bits (even parity), and it is high only together with pix_valid.
- R7: The field outputs change only when pix_valid is high and hold their values otherwise.
- R8: A strobe seen while locked at any slot other than slot 0 restarts the word at slot 0. The partial word is discarded and produces no pix_valid.
- R9: Synchronous active-high reset clears all outputs and the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded bit clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_data | input | LANES | Serial lane bits, one per lane per clock |
| strobe | input | 1 | High in the first slot of a word |
| red | output | 8 | Red channel of the last pixel |
| green | output | 8 | Green channel of the last pixel |
| blue | output | 8 | Blue channel of the last pixel |
| hsync | output | 1 | Horizontal sync of the last pixel |
| vsync | output | 1 | Vertical sync of the last pixel |
| den | output | 1 | Data enable of the last pixel |
| gp | output | 2 | General-purpose bits of the last pixel |
| pix_valid | output | 1 | One-cycle pulse on a new pixel |
| par_err | output | 1 | Parity mismatch on this pixel |

## Verification
A walking single-bit word is sent through all 30 positions, so a swapped lane order or a reversed bit order shows up as a misplaced bit in some field. Words are also streamed with no strobe before lock, and then again after lock. A design that emits pixels before the first strobe, or that needs a strobe on every word, therefore fails. Partial words cut off by an early strobe catch a counter that does not restart, or that emits a pulse for the broken word. Deliberately corrupted parity bits, together with a check that the outputs hold between pulses, catch a wrong parity sense and fields that leak through between words.

// File: rtl/pxd_pkg.sv
`timescale 1ns/1ps
package pxd_pkg;
    localparam int WORD_W  = 30;
    localparam int COLOR_W = 8;
    localparam int GP_W    = 2;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] green;
        logic [COLOR_W-1:0] blue;
        logic               hsync;
        logic               vsync;
        logic               den;
        logic [GP_W-1:0]    gp;
    } pixel_t;

    localparam int PAY_W = $bits(pixel_t);

    function automatic pixel_t word_fields(input logic [WORD_W-1:0] w);
        return pixel_t'(w[WORD_W-1:WORD_W-PAY_W]);
    endfunction

    function automatic logic word_parity_bad(input logic [WORD_W-1:0] w);
        return ^w;
    endfunction
endpackage

// File: rtl/pxd_slot_tracker.sv
`timescale 1ns/1ps
module pxd_slot_tracker #(
    parameter int SLOTS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic active,
    output logic complete
);
    localparam int CW = (SLOTS > 2) ? $clog2(SLOTS) : 1;

    logic          locked_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cur_slot;

    always_comb begin
        active   = locked_q | strobe;
        cur_slot = strobe ? '0 : cnt_q;
        complete = active && (cur_slot == CW'(SLOTS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active) begin
            locked_q <= 1'b1;
            cnt_q    <= complete ? '0 : cur_slot + CW'(1);
        end
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(SLOTS - 1)); // R4
endmodule

// File: rtl/pxd_word_assembler.sv
`timescale 1ns/1ps
module pxd_word_assembler #(
    parameter int LANES  = 3,
    parameter int WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [LANES-1:0]  lane_data,
    output logic [WORD_W-1:0] word
);
    localparam int ACC_W = WORD_W - LANES;

    logic [LANES-1:0] group;
    logic [ACC_W-1:0] acc_q;

    // lane 0 carries the earliest (most significant) bit of each slot
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign group[LANES-1-l] = lane_data[l];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (shift_en) begin
            acc_q <= {acc_q[ACC_W-LANES-1:0], group};
        end
    end

    assign word = {acc_q, group};
endmodule

// File: rtl/pxd_field_unpack.sv
`timescale 1ns/1ps
module pxd_field_unpack
    import pxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output pixel_t            pix_q,
    output logic              valid_q,
    output logic              perr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q   <= '0;
            valid_q <= 1'b0;
            perr_q  <= 1'b0;
        end else begin
            valid_q <= load;
            perr_q  <= load & word_parity_bad(word);
            if (load) begin
                pix_q <= word_fields(word);
            end
        end
    end

    AST_PERR_QUAL: assert property (@(posedge clk) disable iff (rst)
        perr_q |-> valid_q); // R6
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(pix_q)); // R7
endmodule

// File: rtl/pixel_deser.sv
`timescale 1ns/1ps
module pixel_deser
    import pxd_pkg::*;
#(
    parameter int LANES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lane_data,
    input  logic             strobe,
    output logic [7:0]       red,
    output logic [7:0]       green,
    output logic [7:0]       blue,
    output logic             hsync,
    output logic             vsync,
    output logic             den,
    output logic [1:0]       gp,
    output logic             pix_valid,
    output logic             par_err
);
    localparam int SLOTS = WORD_W / LANES;

    logic              active;
    logic              complete;
    logic [WORD_W-1:0] word;
    pixel_t            pix;

    pxd_slot_tracker #(.SLOTS(SLOTS)) u_track (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .active   (active),
        .complete (complete)
    );

    pxd_word_assembler #(.LANES(LANES), .WORD_W(WORD_W)) u_asm (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (active),
        .lane_data (lane_data),
        .word      (word)
    );

    pxd_field_unpack u_unpack (
        .clk     (clk),
        .rst     (rst),
        .load    (complete),
        .word    (word),
        .pix_q   (pix),
        .valid_q (pix_valid),
        .perr_q  (par_err)
    );

    assign red   = pix.red;
    assign green = pix.green;
    assign blue  = pix.blue;
    assign hsync = pix.hsync;
    assign vsync = pix.vsync;
    assign den   = pix.den;
    assign gp    = pix.gp;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> !pix_valid); // R5
    AST_STROBE_NO_PIXEL: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !pix_valid); // R8
endmodule

// File: tb/pixel_deser_bench.sv
`timescale 1ns/1ps
module pixel_deser_bench;
    localparam int L = 3;
    localparam int W = 30;
    localparam int S = W / L;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [L-1:0] ld  = '0;
    logic         stb = 1'b0;
    logic [7:0]   red, green, blue;
    logic         hsync, vsync, den, pix_valid, par_err;
    logic [1:0]   gp;

    int          vecs = 0;
    int          errs = 0;
    bit          pend = 0;
    logic [29:0] pend_w = '0;
    logic [28:0] last_pay = '0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    pixel_deser #(.LANES(L)) u_pixel_deser (
        .clk(clk), .rst(rst), .lane_data(ld), .strobe(stb),
        .red(red), .green(green), .blue(blue), .hsync(hsync),
        .vsync(vsync), .den(den), .gp(gp),
        .pix_valid(pix_valid), .par_err(par_err)
    );

    function automatic logic [28:0] payload();
        return {red, green, blue, hsync, vsync, den, gp};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic observe();
        if (pend) begin
            chk("R5 pulse after last slot", 32'(pix_valid), 32'd1);
            chk("R1/R2 fields", 32'(payload()), 32'(pend_w[29:1]));
            chk("R6 parity flag", 32'(par_err), 32'(^pend_w));
            last_pay = pend_w[29:1];
            pend = 0;
        end else begin
            chk("R3/R8 no pulse", 32'(pix_valid), 32'd0);
            chk("R7 fields hold", 32'(payload()), 32'(last_pay));
            chk("R6 flag idle", 32'(par_err), 32'd0);
        end
    endtask

    task automatic cyc(input logic [L-1:0] d, input logic s);
        @(negedge clk);
        observe();
        ld  = d;
        stb = s;
    endtask

    task automatic send(input logic [29:0] w, input logic s0, input int nslots, input bit expect_px);
        for (int k = 0; k < nslots; k++) begin
            logic [L-1:0] d;
            for (int l = 0; l < L; l++) d[l] = w[29 - (k*L + l)];
            cyc(d, s0 && (k == 0));
        end
        if (expect_px) begin
            pend   = 1;
            pend_w = w;
        end
    endtask

    function automatic logic [29:0] good_par(input logic [29:0] w);
        logic [29:0] r = w;
        r[0] = ^w[29:1];
        return r;
    endfunction

    function automatic logic [29:0] next_rand();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed[29:0];
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    initial begin
        #(200000 * 20);
        errs++;
        $display("FAIL watchdog R5 actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs cleared under reset
        chk("R9 reset valid", 32'(pix_valid), 32'd0);
        chk("R9 reset fields", 32'(payload()), 32'd0);
        chk("R9 reset parity", 32'(par_err), 32'd0);
        rst = 1'b0;

        // R3: no strobe yet, nothing may come out
        for (int i = 0; i < 3; i++) send(next_rand(), 1'b0, S, 1'b0);

        // R2/R1: walking single bit through every position, strobe each word
        for (int i = 0; i < 30; i++) send(30'(1) << i, 1'b1, S, 1'b1);

        // R4: free-running counter, no strobes, mixed parity
        for (int i = 0; i < 24; i++) begin
            logic [29:0] w = good_par(next_rand());
            if (i % 3 == 1) w[0] = ~w[0];
            send(w, 1'b0, S, 1'b1);
        end

        // R8: strobe cuts partial words of several lengths
        for (int p = 1; p < S; p++) begin
            send(good_par(next_rand()), 1'b1, p, 1'b0);
            send(good_par(next_rand()), 1'b1, S, 1'b1);
        end

        // R4: strobe exactly at the expected boundary while locked
        for (int i = 0; i < 4; i++) send(next_rand(), 1'b1, S, 1'b1);

        send(30'h0, 1'b0, S, 1'b1);
        cyc('0, 1'b0);
        cyc('0, 1'b0);
        summary();
        $finish;
    end
endmodule